// File: doc/BRIEF.md
# Power-Save Entry and Wake-Up Sequencer

This block sequences the clock generator through entry into one of four low-power modes (idle, stop, watch and sub-watch) and back out again. Software picks a mode and raises a stop request through a small register write port. The sequencer then accepts the request, waits a fixed number of cycles while the PLL and spread-spectrum clock wind down, and marks entry complete. A wake-up input can arrive at any of these stages.

On a wake-up the block restores a mode-dependent set of clock-control bits. Which bits change depends on the mode and on an oscillator-disable option. A completion flag then tells software how deep entry had gone: the request was refused, it was accepted but unfinished, or it ran to completion. The power and clock registers are guarded. A write to either one takes effect only when the write just before it put the unlock key into the key register. Both registers can be read at any time through a combinational read port.

Register map (byte-wide): address 0 is the key register, address 1 the power register, address 2 the clock register. The power register, when written, holds mode in [1:0] (0 idle, 1 stop, 2 watch, 3 sub-watch), oscillator-disable in [2] and the stop request in [7]. When read, it shows mode [1:0], oscillator-disable [2], sequencer state [4:3] (0 running, 1 accepted, 2 completed), request pending [5] and completion flag [6]. The clock register holds the CPU clock field in [2:0], PLL enable [3], spread-spectrum enable [4], peripheral clock select [5] and the two clock-source selects [6] and [7]. It resets to 8'h18.

Top module: `pwr_seq_top`

## Requirements
- R1: After synchronous reset the sequencer is running with no request pending. The completion flag is 0, the clock register reads 8'h18, PLL and spread-spectrum outputs are on, and the wake strobe is low.
- R2: A write to the power or clock register is applied only if the write immediately before it (idle cycles between them allowed) put 8'hA5 into address 0. Every other such write is discarded. Any write, to any address, uses up a pending key.
- R3: Reads through rd_addr/rd_data are combinational, need no key, and do not use up a pending key.
- R4: In the cycle after a stop request is taken, the sequencer enters the accepted state (unless a wake-up is present in that cycle) and clears the completion flag. The PLL and spread-spectrum outputs stay on while in the accepted state.
- R5: If wake is high in the first cycle after the stop request, the request is dropped. The state stays running, no strobe is issued and the clock register is unchanged.
- R6: With no wake-up, the sequencer stays in the accepted state for exactly 5 cycles and then enters the completed state. On entry to the completed state it sets the completion flag and turns the PLL and spread-spectrum outputs off.
- R7: A wake-up during the accepted state, including its last cycle, returns to running with the restore applied and the completion flag left at 0.
- R8: A wake-up in the completed state returns to running with the restore applied. The completion flag stays 1 until the next accepted request clears it.
- R9: On a restore from stop, watch or sub-watch, clock register bits [7:3] are cleared. On a restore from idle they are kept.
- R10: On a restore, the CPU clock field becomes 000 for idle and stop. For watch and sub-watch it becomes 100 when oscillator-disable is 1 and 000 when it is 0.
- R11: After reset or after a restore, only the first applied clock-register write changes the CPU clock field. Later applied writes update bits [7:3] but leave the field unchanged.
- R12: A power-register write is ignored while a request is pending or while the state is not running.
- R13: The wake strobe is a one-cycle pulse in the cycle after a restore. It is issued only when leaving the accepted or completed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| wake | input | 1 | Wake-up event |
| cpu_clk | output | 3 | CPU clock source/divider field |
| pll_on | output | 1 | PLL enable |
| sscg_on | output | 1 | Spread-spectrum clock enable |
| peri_sel | output | 1 | Peripheral clock select |
| src_sel | output | 2 | Clock source selects |
| wake_applied | output | 1 | One-cycle restore strobe |
| psm_done | output | 1 | Entry completion flag |

## Verification
The main sweep covers every mode and both oscillator-disable settings. In each case the wake-up arrives at every depth from the cycle right after the request to two cycles past completion. This separates the refused, accepted-only and completed outcomes, and it exposes an off-by-one in the five-cycle window at the last accepted cycle. After each wake-up, a clock write with a new CPU field tells a re-armed once-lock from a still-held one. Directed sequences cover bad keys, key-consuming writes, reads between key and write, power writes during entry and a wake-up with nothing requested.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   localparam int REG_W   = 8;
   localparam int REG_KEY = 0;
   localparam int REG_PWR = 1;
   localparam int REG_CLK = 2;

   typedef enum logic [1:0] {
      PM_IDLE  = 2'd0,
      PM_STOP  = 2'd1,
      PM_WATCH = 2'd2,
      PM_SUBW  = 2'd3
   } pmode_t;

   typedef enum logic [1:0] {
      SQ_RUN = 2'd0,
      SQ_ACC = 2'd1,
      SQ_CMP = 2'd2
   } sq_t;

   typedef struct packed {
      logic       src_b;
      logic       src_a;
      logic       peri;
      logic       sscg;
      logic       pll;
      logic [2:0] cpu;
   } clkreg_t;

   // Clock register contents after a wake-up restore.
   function automatic clkreg_t wake_restore(input pmode_t m, input logic osc_off,
                                            input clkreg_t cur);
      clkreg_t r;
      r = cur;
      if (m != PM_IDLE) begin
         r.pll   = 1'b0;
         r.sscg  = 1'b0;
         r.peri  = 1'b0;
         r.src_a = 1'b0;
         r.src_b = 1'b0;
      end
      if (m == PM_WATCH || m == PM_SUBW)
         r.cpu = osc_off ? 3'b100 : 3'b000;
      else
         r.cpu = 3'b000;
      return r;
   endfunction

endpackage

// File: rtl/pwr_seq_gate.sv
module pwr_seq_gate
   import pwr_seq_pkg::*;
#(
   parameter int                ADDR_W  = 2,
   parameter logic [REG_W-1:0]  KEY_VAL = 8'hA5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic              wr_pwr,
   output logic              wr_clk
);

   logic armed;
   logic key_hit;

   assign key_hit = (wr_addr == ADDR_W'(REG_KEY)) && (wr_data == KEY_VAL);

   always_ff @(posedge clk) begin
      if (rst)
         armed <= 1'b0;
      else if (wr_en)
         armed <= key_hit;
   end

   assign wr_pwr = wr_en && armed && (wr_addr == ADDR_W'(REG_PWR));
   assign wr_clk = wr_en && armed && (wr_addr == ADDR_W'(REG_CLK));

   // R2: any write other than the key leaves the gate closed
   p_key_spent_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !key_hit) |=> !armed);

   // R2: an unarmed write never reaches a protected register
   p_need_key_r2: assert property (@(posedge clk) disable iff (rst)
      (!armed) |-> !(wr_pwr || wr_clk));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_seq_pkg::*;
#(
   parameter int ENTRY_CYC = 5
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_pwr,
   input  logic       wr_stop,
   input  logic       wr_osc,
   input  logic [1:0] wr_mode,
   input  logic       wake,
   output sq_t        state,
   output pmode_t     mode,
   output logic       osc_off,
   output logic       req_pend,
   output logic       done,
   output logic       apply,
   output logic       strobe
);

   localparam int CNT_W = (ENTRY_CYC < 2) ? 1 : $clog2(ENTRY_CYC);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic             take_pwr;

   assign take_pwr = wr_pwr && (state == SQ_RUN) && !req_pend;
   assign apply    = wake && ((state == SQ_ACC) || (state == SQ_CMP));

   always_ff @(posedge clk) begin
      if (rst) begin
         mode     <= PM_IDLE;
         osc_off  <= 1'b0;
         req_pend <= 1'b0;
      end else if (take_pwr) begin
         mode     <= pmode_t'(wr_mode);
         osc_off  <= wr_osc;
         req_pend <= wr_stop;
      end else if (state == SQ_RUN && req_pend) begin
         req_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= SQ_RUN;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         unique case (state)
            SQ_RUN: begin
               if (req_pend && !wake) begin
                  state <= SQ_ACC;
                  cnt   <= '0;
                  done  <= 1'b0;
               end
            end
            SQ_ACC: begin
               if (wake) begin
                  state <= SQ_RUN;
               end else if (cnt == CNT_LAST) begin
                  state <= SQ_CMP;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SQ_CMP: begin
               if (wake)
                  state <= SQ_RUN;
            end
            default: state <= SQ_RUN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         strobe <= 1'b0;
      else
         strobe <= apply;
   end

   // R4: a pending request without wake-up is accepted and clears the flag
   p_accept_r4: assert property (@(posedge clk) disable iff (rst)
      (state == SQ_RUN && req_pend && !wake) |=> (state == SQ_ACC && !done));

   // R5: a wake-up in the first cycle drops the request
   p_refuse_r5: assert property (@(posedge clk) disable iff (rst)
      (state == SQ_RUN && req_pend && wake) |=> (state == SQ_RUN && !req_pend && !strobe));

   // R6: the completed state always carries the completion flag
   p_cmp_done_r6: assert property (@(posedge clk) disable iff (rst)
      (state == SQ_CMP) |-> done);

   // R7: no completion flag while entry is still in progress
   p_acc_flag_r7: assert property (@(posedge clk) disable iff (rst)
      (state == SQ_ACC) |-> !done);

   // R8: flag survives a wake-up out of the completed state
   p_keep_flag_r8: assert property (@(posedge clk) disable iff (rst)
      (state == SQ_CMP && wake) |=> (done && state == SQ_RUN));

   // R13: strobe is one cycle wide and follows a deep state
   p_strobe_one_r13: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe);
   p_strobe_src_r13: assert property (@(posedge clk) disable iff (rst)
      strobe |-> ($past(state) != SQ_RUN));

   // R12: power writes do not change mode outside the idle running state
   p_pwr_blocked_r12: assert property (@(posedge clk) disable iff (rst)
      (wr_pwr && (state != SQ_RUN || req_pend)) |=> $stable(mode));

endmodule

// File: rtl/pwr_seq_clk.sv
module pwr_seq_clk
   import pwr_seq_pkg::*;
#(
   parameter logic [REG_W-1:0] CLK_RST  = 8'h18,
   parameter bit               CLK_ONCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_clk,
   input  logic [REG_W-1:0] wr_data,
   input  logic             apply,
   input  pmode_t           mode,
   input  logic             osc_off,
   output clkreg_t          q
);

   clkreg_t wd;
   logic    lock_q;

   assign wd = clkreg_t'(wr_data);

   generate
      if (CLK_ONCE) begin : g_once
         logic lock_r;
         always_ff @(posedge clk) begin
            if (rst)
               lock_r <= 1'b0;
            else if (apply)
               lock_r <= 1'b0;
            else if (wr_clk)
               lock_r <= 1'b1;
         end
         assign lock_q = lock_r;

         // R11: a locked CPU field ignores further software writes
         p_cpu_locked_r11: assert property (@(posedge clk) disable iff (rst)
            (lock_r && wr_clk && !apply) |=> $stable(q.cpu));
      end else begin : g_free
         assign lock_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= clkreg_t'(CLK_RST);
      end else if (apply) begin
         q <= wake_restore(mode, osc_off, q);
      end else if (wr_clk) begin
         q.pll   <= wd.pll;
         q.sscg  <= wd.sscg;
         q.peri  <= wd.peri;
         q.src_a <= wd.src_a;
         q.src_b <= wd.src_b;
         if (!lock_q)
            q.cpu <= wd.cpu;
      end
   end

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
   import pwr_seq_pkg::*;
#(
   parameter int               ADDR_W    = 2,
   parameter logic [REG_W-1:0] KEY_VAL   = 8'hA5,
   parameter int               ENTRY_CYC = 5,
   parameter logic [REG_W-1:0] CLK_RST   = 8'h18,
   parameter bit               CLK_ONCE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic              wake,
   output logic [2:0]        cpu_clk,
   output logic              pll_on,
   output logic              sscg_on,
   output logic              peri_sel,
   output logic [1:0]        src_sel,
   output logic              wake_applied,
   output logic              psm_done
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("pwr_seq_top: ADDR_W must be at least 2");
      end
      if (ENTRY_CYC < 1 || ENTRY_CYC > 65535) begin : g_bad_entry
         $error("pwr_seq_top: ENTRY_CYC out of range");
      end
   endgenerate

   logic    wr_pwr, wr_clk;
   sq_t     state;
   pmode_t  mode;
   logic    osc_off, req_pend, done, apply, strobe;
   clkreg_t creg;

   pwr_seq_gate #(.ADDR_W(ADDR_W), .KEY_VAL(KEY_VAL)) u_gate (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_pwr(wr_pwr), .wr_clk(wr_clk)
   );

   pwr_seq_fsm #(.ENTRY_CYC(ENTRY_CYC)) u_fsm (
      .clk(clk), .rst(rst), .wr_pwr(wr_pwr),
      .wr_stop(wr_data[7]), .wr_osc(wr_data[2]), .wr_mode(wr_data[1:0]),
      .wake(wake), .state(state), .mode(mode), .osc_off(osc_off),
      .req_pend(req_pend), .done(done), .apply(apply), .strobe(strobe)
   );

   pwr_seq_clk #(.CLK_RST(CLK_RST), .CLK_ONCE(CLK_ONCE)) u_clk (
      .clk(clk), .rst(rst), .wr_clk(wr_clk), .wr_data(wr_data), .apply(apply),
      .mode(mode), .osc_off(osc_off), .q(creg)
   );

   always_comb begin
      if (rd_addr == ADDR_W'(REG_PWR))
         rd_data = {1'b0, done, req_pend, state, osc_off, mode};
      else if (rd_addr == ADDR_W'(REG_CLK))
         rd_data = creg;
      else
         rd_data = '0;
   end

   assign cpu_clk      = creg.cpu;
   assign pll_on       = creg.pll  && (state != SQ_CMP);
   assign sscg_on      = creg.sscg && (state != SQ_CMP);
   assign peri_sel     = creg.peri;
   assign src_sel      = {creg.src_b, creg.src_a};
   assign wake_applied = strobe;
   assign psm_done     = done;

   // R9: deep modes leave every PLL-related bit cleared after a restore
   p_restore_bits_r9: assert property (@(posedge clk) disable iff (rst)
      (apply && mode != PM_IDLE) |=> (!pll_on && !sscg_on && !peri_sel && src_sel == 2'b00));

   // R10: watch modes pick the CPU field from the oscillator option
   p_watch_cpu_r10: assert property (@(posedge clk) disable iff (rst)
      (apply && (mode == PM_WATCH || mode == PM_SUBW)) |=> (cpu_clk == {osc_off, 2'b00}));

   // R10: idle and stop clear the CPU field
   p_plain_cpu_r10: assert property (@(posedge clk) disable iff (rst)
      (apply && (mode == PM_IDLE || mode == PM_STOP)) |=> (cpu_clk == 3'b000));

   // R6: no clock enables while entry is complete
   p_cmp_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      (psm_done && !wake_applied && rd_addr == ADDR_W'(REG_CLK) && state == SQ_CMP)
         |-> !(pll_on || sscg_on));

endmodule

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;

   localparam int         CLK_PERIOD = 10;
   localparam logic [7:0] KEY        = 8'hA5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       wake = 1'b0;
   logic [2:0] cpu_clk;
   logic       pll_on, sscg_on, peri_sel, wake_applied, psm_done;
   logic [1:0] src_sel;

   int total = 0;
   int bad   = 0;

   pwr_seq_top u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .wake(wake), .cpu_clk(cpu_clk),
      .pll_on(pll_on), .sscg_on(sscg_on), .peri_sel(peri_sel), .src_sel(src_sel),
      .wake_applied(wake_applied), .psm_done(psm_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pwr(input logic [1:0] a, input logic [7:0] d);
      wr(2'd0, KEY);
      wr(a, d);
   endtask

   task automatic rdreg(input logic [1:0] a, output logic [7:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   function automatic logic [7:0] exp_restore(input int m, input int osc, input logic [7:0] cur);
      logic [7:0] r;
      r = cur;
      if (m != 0) r[7:3] = 5'd0;
      if (m >= 2) r[2:0] = (osc != 0) ? 3'b100 : 3'b000;
      else        r[2:0] = 3'b000;
      return r;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [7:0] e;

      do_reset();
      // R1 reset state
      rdreg(2'd1, v); chk("R1 power reg", v, 8'h00);
      rdreg(2'd2, v); chk("R1 clock reg", v, 8'h18);
      chk("R1 pll/sscg on", {pll_on, sscg_on}, 2'b11);
      chk("R1 done/strobe", {psm_done, wake_applied}, 2'b00);

      // R13 wake with nothing requested does nothing
      @(negedge clk); wake = 1'b1;
      @(negedge clk); wake = 1'b0;
      chk("R13 no strobe from running", wake_applied, 0);
      rdreg(2'd2, v); chk("R13 clock untouched", v, 8'h18);

      // R2 protection
      wr(2'd2, 8'hFF);
      rdreg(2'd2, v); chk("R2 no key", v, 8'h18);
      wr(2'd0, 8'h5A); wr(2'd2, 8'hFF);
      rdreg(2'd2, v); chk("R2 wrong key", v, 8'h18);
      wr(2'd0, KEY); wr(2'd3, 8'h00); wr(2'd2, 8'hFF);
      rdreg(2'd2, v); chk("R2 key spent by other write", v, 8'h18);
      pwr(2'd2, 8'hFF);
      rdreg(2'd2, v); chk("R2 keyed write applied", v, 8'hFF);

      // R3 reads between key and write do not spend the key; R11 lock
      wr(2'd0, KEY);
      rdreg(2'd1, v); rdreg(2'd3, v); rdreg(2'd2, v);
      chk("R3 read without key", v, 8'hFF);
      wr(2'd2, 8'h00);
      rdreg(2'd2, v); chk("R3 R11 key kept, cpu locked", v, 8'h07);

      // Sweep: mode x oscillator option x wake depth
      for (int m = 0; m < 4; m++) begin
         for (int osc = 0; osc < 2; osc++) begin
            for (int d = 0; d < 8; d++) begin
               do_reset();
               pwr(2'd2, 8'hFF);
               rdreg(2'd2, v); chk("R11 first clock write", v, 8'hFF);
               pwr(2'd1, {1'b1, 4'd0, osc[0], m[1:0]});
               for (int c = 0; c <= d; c++) begin
                  if (c > 0) @(negedge clk);
                  rdreg(2'd1, v);
                  if (c == 0) begin
                     chk("R4 pending before accept", {v[5], v[4:3]}, 3'b100);
                  end else if (c <= 5) begin
                     chk("R4 accepted state", v[4:3], 1);
                     chk("R4 flag low, clocks on", {psm_done, pll_on, sscg_on}, 3'b011);
                  end else begin
                     chk("R6 completed state", v[4:3], 2);
                     chk("R6 flag set, clocks off", {psm_done, pll_on, sscg_on}, 3'b100);
                  end
                  if (c == d) wake = 1'b1;
               end
               @(negedge clk);
               wake = 1'b0;
               rdreg(2'd1, v);
               chk("R5 R7 R8 back to running", {v[5], v[4:3]}, 3'b000);
               chk("R13 strobe on deep wake", wake_applied, (d >= 1) ? 1 : 0);
               chk("R7 R8 completion flag", psm_done, (d >= 6) ? 1 : 0);
               e = (d >= 1) ? exp_restore(m, osc, 8'hFF) : 8'hFF;
               rdreg(2'd2, v); chk("R9 R10 R5 restored clock reg", v, e);
               @(negedge clk);
               chk("R13 strobe one cycle", wake_applied, 0);
               pwr(2'd2, 8'h01);
               rdreg(2'd2, v); chk("R11 lock after wake", v, (d >= 1) ? 8'h01 : 8'h07);
            end
         end
      end

      // R12 power write during entry; R8 flag held until next acceptance
      do_reset();
      pwr(2'd1, 8'h81);
      wr(2'd0, KEY);
      wr(2'd1, 8'h82);
      rdreg(2'd1, v);
      chk("R12 mode kept during entry", {v[4:3], v[1:0]}, 4'b0101);
      repeat (3) @(negedge clk);
      rdreg(2'd1, v); chk("R6 completed after window", v[4:3], 2);
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      chk("R8 flag after deep wake", psm_done, 1);
      repeat (3) @(negedge clk);
      chk("R8 flag held while running", psm_done, 1);
      pwr(2'd1, 8'h80);
      @(negedge clk);
      rdreg(2'd1, v);
      chk("R8 flag cleared by new acceptance", {psm_done, v[4:3], v[1:0]}, 5'b00100);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule